// File: doc/BRIEF.md
# Edge-Triggered Prioritized Interrupt Resolver

This block takes eleven active-high request lines from expansion cards and turns them into a single interrupt for the processor. Each line is synchronized into the system clock domain. A low-to-high transition on a synchronized line marks that line as pending. The pending mark stays set until the processor acknowledges that line, or until the card lets the line fall first.

Among the pending lines that are not masked, a fixed, non-numeric ranking chooses a winner. Lines 9, 10, 11 and 12, then 14 and 15, rank above lines 3, 4, 5, 6 and 7. The output stage registers the winning line number together with a valid flag.

The processor side behaves like a stream consumer. `irq_valid` offers the vector in `irq_vec`, and `irq_ack` acts as the ready strobe. A cycle in which both are high consumes the offered vector, which clears that one pending bit. While valid is high and no acknowledge arrives, the offer stays in place. Three things can change it without a handshake:
- a higher-ranked line becomes pending, which preempts it;
- the offered line drops, which cancels it;
- the mask changes.

An acknowledge while valid is low is discarded.

Top module: `irq_resolver`

## Requirements
- R1: Port bit i of `irq_lines` and `irq_mask` maps to a line number: bits 0..4 are lines 3..7, bits 5..8 are lines 9..12, bit 9 is line 14 and bit 10 is line 15. `irq_vec` carries the winning line number in plain binary (4 bits).
- R2: Only a rising edge makes a line pending. A line held high after its acknowledge raises no new request until it has gone low and risen again.
- R3: A line rising between clock edges is reported (`irq_valid` high, `irq_vec` = its number) on the fourth rising clock edge after the change, not earlier.
- R4: When several unmasked lines are pending, the reported line follows the ranking 9, 10, 11, 12, 14, 15, 3, 4, 5, 6, 7 (highest first). A newly pending higher-ranked line preempts the current one.
- R5: A line that falls before acknowledge cancels its request; the report disappears on the fourth rising edge after the fall.
- R6: A clock edge with `irq_valid` and `irq_ack` both high clears only the pending bit of the reported line. The outputs reflect this on the second rising edge after the acknowledge is sampled.
- R7: A masked line (mask bit = 1) can still become pending but is never reported. Clearing the mask bit lets it be reported on the next rising edge.
- R8: With no pending unmasked line, `irq_valid` is low and `irq_vec` is 0.
- R9: During and right after reset, `irq_valid` is 0 and `irq_vec` is 0, and nothing is pending.
- R10: `irq_ack` sampled while `irq_valid` is low has no effect on any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 11 | Asynchronous request lines from cards, mapped per R1 |
| irq_mask | input | 11 | Per-line mask, 1 excludes the line from arbitration |
| irq_ack | input | 1 | Processor acknowledge (ready) for the offered vector |
| irq_valid | output | 1 | A vector is being offered |
| irq_vec | output | 4 | Line number of the winning request, 0 when idle |

## Verification
The hardest state to reach is a line whose level is still high while its pending bit is already clear. From outside, this line looks exactly like a fresh request, so the bench has to show that no edge is inferred from the level alone. The stimulus gets there by keeping two lines high, acknowledging both in turn, and then watching the outputs stay idle for several cycles. After that, the bench drops one line and raises it again to show that a fresh edge re-arms it. A masked pending line paired with a stray acknowledge is also covered: the valid-low acknowledge must not disturb the hidden pending bit, and the bench brings that bit out by unmasking it.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Number of physical request lines and width of the line-number vector.
  localparam int unsigned LINE_CNT = 11;
  localparam int unsigned VEC_BITS = 4;
  // First port index of the high-ranked group (lines 9..15).
  localparam int unsigned HI_BASE  = 5;
  localparam int unsigned HI_CNT   = LINE_CNT - HI_BASE;

  // Port index -> line number.
  function automatic int unsigned idx_to_line(int unsigned idx);
    if (idx < 5)      return idx + 3;
    else if (idx < 9) return idx + 4;
    else              return idx + 5;
  endfunction

  // Line number -> port index (unused numbers fold to 0).
  function automatic int unsigned line_to_idx(int unsigned line);
    if (line >= 3 && line <= 7)        return line - 3;
    else if (line >= 9 && line <= 12)  return line - 4;
    else if (line == 14 || line == 15) return line - 5;
    else                               return 0;
  endfunction

  // Rank (0 = highest) -> port index.
  function automatic int unsigned rank_to_idx(int unsigned rank);
    if (rank < HI_CNT) return rank + HI_BASE;
    else               return rank - HI_CNT;
  endfunction

  function automatic logic is_real_line(int unsigned line);
    return (line >= 3 && line <= 7) || (line >= 9 && line <= 12) ||
           line == 14 || line == 15;
  endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned WIDTH  = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in[g]};
    end

    assign sync_out[g] = chain_q[LAST];
  end

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int unsigned WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic [WIDTH-1:0] clr_in,
  output logic [WIDTH-1:0] rise_out,
  output logic [WIDTH-1:0] pend_out
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] pend_d;

  assign rise_out = level_in & ~prev_q;

  // A falling level cancels; an acknowledge clear beats a same-cycle edge.
  always_comb begin
    pend_d = (pend_q | rise_out) & level_in & ~clr_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= level_in;
      pend_q <= pend_d;
    end
  end

  assign pend_out = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned VEC_W = 4
) (
  input  logic [WIDTH-1:0] cand_in,
  output logic             any_out,
  output logic [VEC_W-1:0] line_out
);

  import irq_pkg::*;

  logic [WIDTH-1:0] by_rank;
  logic [WIDTH:0]   taken;
  logic [WIDTH-1:0] win;
  logic [VEC_W-1:0] term [WIDTH];

  assign taken[0] = 1'b0;

  for (genvar r = 0; r < WIDTH; r++) begin : g_rank
    localparam int unsigned IDX  = rank_to_idx(r);
    localparam int unsigned LINE = idx_to_line(IDX);

    assign by_rank[r]  = cand_in[IDX];
    assign win[r]      = by_rank[r] & ~taken[r];
    assign taken[r+1]  = taken[r] | by_rank[r];
    assign term[r]     = win[r] ? VEC_W'(LINE) : '0;
  end

  always_comb begin
    line_out = '0;
    for (int r = 0; r < WIDTH; r++) line_out = line_out | term[r];
  end

  assign any_out = taken[WIDTH];

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int unsigned NUM_LINES   = irq_pkg::LINE_CNT,
  parameter int unsigned VEC_W       = irq_pkg::VEC_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [NUM_LINES-1:0] irq_mask,
  input  logic                 irq_ack,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vec
);

  import irq_pkg::*;

  logic [NUM_LINES-1:0] sync_lvl;
  logic [NUM_LINES-1:0] rise_w;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] clr_w;
  logic [NUM_LINES-1:0] cand_w;
  logic                 any_w;
  logic [VEC_W-1:0]     line_w;

  irq_sync_bank #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_lines),
    .sync_out (sync_lvl)
  );

  // Consume handshake: clear only the bit behind the offered vector.
  always_comb begin
    clr_w = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (irq_valid && irq_ack && (idx_to_line(i) == 32'(irq_vec)))
        clr_w[i] = 1'b1;
    end
  end

  irq_pend_track #(.WIDTH(NUM_LINES)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (sync_lvl),
    .clr_in   (clr_w),
    .rise_out (rise_w),
    .pend_out (pend_q)
  );

  assign cand_w = pend_q & ~irq_mask;

  irq_prio_pick #(.WIDTH(NUM_LINES), .VEC_W(VEC_W)) u_pick (
    .cand_in  (cand_w),
    .any_out  (any_w),
    .line_out (line_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
    end else begin
      irq_valid <= any_w;
      irq_vec   <= any_w ? line_w : '0;
    end
  end

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned NUM_LINES = 11,
  parameter int unsigned VEC_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_mask,
  input logic                 irq_ack,
  input logic                 irq_valid,
  input logic [VEC_W-1:0]     irq_vec,
  input logic [NUM_LINES-1:0] sync_lvl,
  input logic [NUM_LINES-1:0] rise_w,
  input logic [NUM_LINES-1:0] pend_q
);

  import irq_pkg::*;

  logic [NUM_LINES-1:0] mask_d;
  always_ff @(posedge clk) begin
    if (!rst_n) mask_d <= '0;
    else        mask_d <= irq_mask;
  end

  // R8
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_vec == '0);

  // R1
  legal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> is_real_line(32'(irq_vec)));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack) |=> !pend_q[line_to_idx(32'($past(irq_vec)))]);

  // R7
  masked_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !mask_d[line_to_idx(32'(irq_vec))]);

  // R2
  set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(rise_w)) == '0));

  // R5
  pend_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(sync_lvl)) == '0));

endmodule

bind irq_resolver irq_resolver_chk #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_mask  (irq_mask),
  .irq_ack   (irq_ack),
  .irq_valid (irq_valid),
  .irq_vec   (irq_vec),
  .sync_lvl  (sync_lvl),
  .rise_w    (rise_w),
  .pend_q    (pend_q)
);

// File: tb/test_irq_resolver.sv
module test_irq_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int N = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_lines = '0;
  logic [N-1:0]  irq_mask = '0;
  logic          irq_ack = 1'b0;
  logic          irq_valid;
  logic [3:0]    irq_vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_resolver i_irq_resolver (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .irq_mask(irq_mask),
    .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  // {lines, mask, valid, vec}; bit map per R1 (bit0=line3 .. bit10=line15)
  localparam logic [26:0] TBL [9] = '{
    {11'h001, 11'h000, 1'b1, 4'd3},
    {11'h7FF, 11'h000, 1'b1, 4'd9},
    {11'h01F, 11'h000, 1'b1, 4'd3},
    {11'h600, 11'h000, 1'b1, 4'd14},
    {11'h410, 11'h000, 1'b1, 4'd15},
    {11'h7FF, 11'h3FF, 1'b1, 4'd15},
    {11'h0C0, 11'h040, 1'b1, 4'd11},
    {11'h7FF, 11'h7FF, 1'b0, 4'd0},
    {11'h018, 11'h000, 1'b1, 4'd6}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(3);
    // R9 reset state
    check("R9 valid", int'(irq_valid), 0);
    check("R9 vec", int'(irq_vec), 0);
    rst_n = 1'b1;
    step(2);
    check("R9 valid after release", int'(irq_valid), 0);

    // Vector table: R1, R4, R7, R8
    for (int k = 0; k < 9; k++) begin
      irq_lines = '0;
      irq_mask  = TBL[k][15:5];
      step(5);
      irq_lines = TBL[k][26:16];
      step(5);
      check($sformatf("R4 table %0d valid", k), int'(irq_valid), int'(TBL[k][4]));
      check($sformatf("R1 table %0d vec", k), int'(irq_vec), int'(TBL[k][3:0]));
    end
    irq_lines = '0; irq_mask = '0;
    step(5);
    check("R8 idle valid", int'(irq_valid), 0);
    check("R8 idle vec", int'(irq_vec), 0);

    // R3 latency: line 5 (bit2)
    irq_lines = 11'h004;
    step(3);
    check("R3 not before 4th edge", int'(irq_valid), 0);
    step(1);
    check("R3 valid at 4th edge", int'(irq_valid), 1);
    check("R3 vec", int'(irq_vec), 5);

    // R4 preemption: line 14 rises while 5 is offered
    irq_lines = 11'h204;
    step(4);
    check("R4 preempt", int'(irq_vec), 14);

    // R5 cancel by falling line 14
    irq_lines = 11'h004;
    step(3);
    check("R5 still held", int'(irq_vec), 14);
    step(1);
    check("R5 cancel falls back", int'(irq_vec), 5);
    irq_lines = '0;
    step(5);

    // R6 acknowledge clears only reported line: lines 9,10
    irq_lines = 11'h060;
    step(5);
    check("R6 first", int'(irq_vec), 9);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    check("R6 unchanged first edge", int'(irq_vec), 9);
    step(1);
    check("R6 next line", int'(irq_vec), 10);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0; step(1);
    check("R6 all cleared", int'(irq_valid), 0);

    // R2 held level does not re-request
    step(6);
    check("R2 no retrigger", int'(irq_valid), 0);
    irq_lines = 11'h040;
    step(5);
    irq_lines = 11'h060;
    step(5);
    check("R2 fresh edge", int'(irq_vec), 9);
    irq_lines = '0;
    step(5);

    // R7 masked pending, revealed on unmask
    irq_mask  = 11'h020;
    irq_lines = 11'h021;
    step(5);
    check("R7 masked skipped", int'(irq_vec), 3);
    irq_mask = '0;
    step(1);
    check("R7 unmask next edge", int'(irq_vec), 9);
    irq_lines = '0;
    step(5);

    // R10 ack while valid low leaves hidden pending bit
    irq_mask  = 11'h100;
    irq_lines = 11'h100;
    step(5);
    check("R10 hidden", int'(irq_valid), 0);
    irq_ack = 1'b1; step(2); irq_ack = 1'b0;
    irq_mask = '0;
    step(1);
    check("R10 valid kept", int'(irq_valid), 1);
    check("R10 vec", int'(irq_vec), 12);

    finish_run();
  end

endmodule